// File: doc/BRIEF.md
# HDLC Transmit Framer

The framer turns a byte-wide stream of frame octets into a single serial bit line. Octets arrive on a valid/ready handshake with a marker on the final octet of each frame. Output bits advance only on cycles where the bit-clock enable is high, so the block runs from the system clock while the line rate is set elsewhere.

Each frame goes out as a flag (0x7E), the payload octets, a frame check sequence and another flag. Payload octets are sent least significant bit first. The check sequence is sent most significant coefficient first. Every bit between the flags passes through zero insertion, so the flag pattern cannot appear inside a frame. When no octet is waiting, the line carries back-to-back flags. A configuration input chooses a 16-bit or 32-bit check sequence for each frame. Address and control octets are treated as ordinary payload.

Top module: `hdlc_tx_framer`

## Requirements
- R1: Each frame is sent as a flag, then the accepted octets in order, then the check sequence, then a flag. The flag that closes one frame may also open the next.
- R2: While no frame is in progress and in_valid is low, the line carries continuous flags.
- R3: Each payload octet is sent bit 0 first and bit 7 last.
- R4: Inside a frame (payload and check sequence), a 0 is inserted after every five consecutive 1s. This includes a run of five 1s that ends the check sequence, just before the closing flag.
- R5: The bits of a flag are never zero-inserted, so each flag carries its six consecutive 1s.
- R6: With fcs32_sel=0, the check sequence uses x^16+x^12+x^5+1, preset to all ones, computed over the payload bits in line order. Its ones' complement is sent starting with the x^15 coefficient.
- R7: With fcs32_sel=1, the check sequence uses the 32-bit polynomial 0x04C11DB7, preset to all ones, computed the same way. Its ones' complement is sent starting with the x^31 coefficient.
- R8: fcs32_sel is sampled only when the first octet of a frame is accepted. Changing it later in the frame has no effect on that frame.
- R9: in_ready is high only in a cycle with bit_en high, on the last bit of a flag or of a non-final octet, and never while an inserted zero is due. An octet is taken at a rising clock edge where in_valid and in_ready are both high.
- R10: If in_valid is low at the end of a non-final octet, the frame is closed there with its check sequence and flag. Later octets start a new frame.
- R11: tx_bit changes only at a clock edge where bit_en is high, and it is 1 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Line bit-clock enable; one output bit per high cycle |
| fcs32_sel | input | 1 | 1 selects the 32-bit check sequence, 0 the 16-bit one |
| in_data | input | 8 | Frame octet |
| in_valid | input | 1 | in_data holds an octet |
| in_last | input | 1 | The octet is the last of its frame |
| in_ready | output | 1 | The octet is taken at this clock edge if in_valid is high |
| tx_bit | output | 1 | Serial line data |

## Verification
The embedded assertions check the following on every cycle:
- tx_bit holds between enables.
- in_ready appears only on an enable and never while an inserted zero is due.
- A due zero really appears on the line.
- No octet is requested during the check sequence.

Some behaviours only the bench's scenarios can show: that the line decodes into the expected frames, that payload bit order is correct, that both check sequences are correct, that the width latched at frame start wins over later changes, that an underrun splits the frame, and that idle flags are sent. The bench shows these by receiving the line with its own flag-and-destuffing decoder and its own reflected check arithmetic.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

  localparam int          OCTET_W    = 8;
  localparam logic [7:0]  FLAG_OCTET = 8'h7E;
  localparam int          STUFF_RUN  = 5;
  localparam logic [15:0] POLY16     = 16'h1021;
  localparam logic [31:0] POLY32     = 32'h04C1_1DB7;

  typedef enum logic [1:0] {SEG_FLAG, SEG_DATA, SEG_FCS} seg_e;

  // register preset for a new frame
  function automatic logic [31:0] fcs_preset(input logic wide);
    return wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  endfunction

  // advance the check register by one line-order data bit
  function automatic logic [31:0] fcs_advance(input logic [31:0] c, input logic b,
                                               input logic wide);
    logic        fb;
    logic [15:0] low;
    if (wide) begin
      fb = c[31] ^ b;
      return {c[30:0], 1'b0} ^ (fb ? POLY32 : 32'h0);
    end
    fb  = c[15] ^ b;
    low = {c[14:0], 1'b0} ^ (fb ? POLY16 : 16'h0);
    return {16'h0, low};
  endfunction

  // complemented check, left-aligned so bit 31 is sent first
  function automatic logic [31:0] fcs_tx_image(input logic [31:0] c, input logic wide);
    return wide ? ~c : {~c[15:0], 16'h0};
  endfunction

  // number of line bits in a segment, zero insertion excluded
  function automatic logic [5:0] seg_bits(input seg_e s, input logic wide);
    if (s == SEG_FCS) return wide ? 6'd32 : 6'd16;
    return 6'(OCTET_W);
  endfunction

endpackage

// File: rtl/hdlc_fcs_gen.sv
module hdlc_fcs_gen
  import hdlc_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        preset,
  input  logic        preset_wide,
  input  logic        adv,
  input  logic        wide,
  input  logic        din,
  output logic [31:0] crc_nxt
);
  logic [31:0] crc_q;

  assign crc_nxt = fcs_advance(crc_q, din, wide);

  always_ff @(posedge clk) begin
    if (!rst_n)      crc_q <= 32'hFFFF_FFFF;
    else if (preset) crc_q <= fcs_preset(preset_wide);
    else if (adv)    crc_q <= crc_nxt;
  end
endmodule

// File: rtl/hdlc_zero_ins.sv
module hdlc_zero_ins #(
  parameter int RUN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic in_region,
  input  logic sent_bit,
  output logic stuff_due
);
  localparam int CW = $clog2(RUN + 1);
  logic [CW-1:0] run_q;

  assign stuff_due = (run_q == CW'(RUN));

  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= '0;
    else if (bit_en) begin
      if (stuff_due || !in_region || !sent_bit) run_q <= '0;
      else                                     run_q <= run_q + CW'(1);
    end
  end
endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
  import hdlc_tx_pkg::*;
#(
  parameter int ONES_LIMIT = STUFF_RUN
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       fcs32_sel,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_last,
  output logic       in_ready,
  output logic       tx_bit
);
  seg_e        seg_q;
  logic [5:0]  idx_q;
  logic [31:0] sh_q;
  logic        last_q, wide_q, tx_q;

  // named internal events
  logic        cur_bit, unit_end, stuff_due, emit, can_take, take, start_frame;
  logic [5:0]  seg_len;
  logic [31:0] crc_nxt, fcs_img;

  always_comb begin
    case (seg_q)
      SEG_FLAG: cur_bit = FLAG_OCTET[idx_q[2:0]];
      SEG_DATA: cur_bit = sh_q[0];
      default:  cur_bit = sh_q[31];
    endcase
  end

  assign seg_len     = seg_bits(seg_q, wide_q);
  assign unit_end    = (idx_q == seg_len - 6'd1);
  assign emit        = bit_en && !stuff_due;
  assign can_take    = (seg_q == SEG_FLAG) || ((seg_q == SEG_DATA) && !last_q);
  assign in_ready    = emit && unit_end && can_take;
  assign take        = in_ready && in_valid;
  assign start_frame = take && (seg_q == SEG_FLAG);
  assign fcs_img     = fcs_tx_image(crc_nxt, wide_q);
  assign tx_bit      = tx_q;

  hdlc_fcs_gen u_fcs (
    .clk         (clk),
    .rst_n       (rst_n),
    .preset      (start_frame),
    .preset_wide (fcs32_sel),
    .adv         (emit && (seg_q == SEG_DATA)),
    .wide        (wide_q),
    .din         (cur_bit),
    .crc_nxt     (crc_nxt)
  );

  hdlc_zero_ins #(.RUN(ONES_LIMIT)) u_zins (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .in_region (seg_q != SEG_FLAG),
    .sent_bit  (cur_bit),
    .stuff_due (stuff_due)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg_q  <= SEG_FLAG;
      idx_q  <= '0;
      sh_q   <= '0;
      last_q <= 1'b0;
      wide_q <= 1'b0;
      tx_q   <= 1'b1;
    end else if (bit_en) begin
      if (stuff_due) begin
        tx_q <= 1'b0;
      end else begin
        tx_q <= cur_bit;
        if (unit_end) begin
          idx_q <= '0;
          case (seg_q)
            SEG_FLAG: if (take) begin
              seg_q  <= SEG_DATA;
              sh_q   <= {24'h0, in_data};
              last_q <= in_last;
              wide_q <= fcs32_sel;
            end
            SEG_DATA: if (take) begin
              sh_q   <= {24'h0, in_data};
              last_q <= in_last;
            end else begin
              seg_q <= SEG_FCS;
              sh_q  <= fcs_img;
            end
            default: seg_q <= SEG_FLAG;
          endcase
        end else begin
          idx_q <= idx_q + 6'd1;
          if (seg_q == SEG_DATA)     sh_q <= sh_q >> 1;
          else if (seg_q == SEG_FCS) sh_q <= sh_q << 1;
        end
      end
    end
  end

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(tx_bit));

  assert_ready_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (bit_en && !stuff_due));

  assert_stuff_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && stuff_due) |=> !tx_bit);

  assert_no_take_in_fcs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_q == SEG_FCS) |-> !in_ready);

endmodule

// File: tb/hdlc_tx_framer_bench.sv
`timescale 1ns/1ps
module hdlc_tx_framer_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, bit_en = 1'b0, fcs32_sel = 1'b0;
  logic [7:0] in_data = 8'h0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic in_ready, tx_bit;

  hdlc_tx_framer u_hdlc_tx_framer (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fcs32_sel(fcs32_sel),
    .in_data(in_data), .in_valid(in_valid), .in_last(in_last),
    .in_ready(in_ready), .tx_bit(tx_bit)
  );

  int checks = 0, errors = 0;
  int div = 1, bcnt = 0;
  logic ben_q = 1'b0;
  int ben_total = 0, last_take = 0;

  // expected frames
  logic [7:0] exp_byte [0:1023];
  int exp_start [0:255];
  int exp_len   [0:255];
  logic exp_wide [0:255];
  int exp_n = 0, exp_ptr = 0, rx_n = 0;

  // decoder state
  logic rxb [0:2047];
  int nb = 0, ones = 0, flags = 0, aborts = 0;
  bit synced = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  always @(negedge clk) begin
    bit_en <= (bcnt == 0);
    bcnt   <= (bcnt + 1 >= div) ? 0 : bcnt + 1;
  end

  always @(posedge clk) begin
    ben_q <= bit_en && rst_n;
    if (rst_n && bit_en) ben_total <= ben_total + 1;
  end

  task automatic close_frame();
    int k, w, len, base;
    logic [31:0] r, m, p;
    logic [7:0] v;
    logic fb;
    k = rx_n;
    rx_n++;
    if (k >= exp_n) begin chk(0, "R1 unexpected frame", k, exp_n); return; end
    w = exp_wide[k] ? 32 : 16; len = exp_len[k]; base = exp_start[k];
    chk(nb == 8*len + w, "R1 frame bit count", nb, 8*len + w);
    if (nb != 8*len + w) return;
    for (int j = 0; j < len; j++) begin
      for (int i = 0; i < 8; i++) v[i] = rxb[8*j + i];
      chk(v == exp_byte[base + j], "R3 payload octet", v, exp_byte[base + j]);
    end
    r = (w == 32) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    for (int i = 0; i < 8*len; i++) begin
      fb = r[0] ^ rxb[i];
      r  = r >> 1;
      if (fb) r = r ^ ((w == 32) ? 32'hEDB8_8320 : 32'h0000_8408);
    end
    p = 0;
    for (int i = 0; i < w; i++) p[i] = rxb[8*len + i];
    m = (w == 32) ? ~r : (~r & 32'h0000_FFFF);
    chk(p == m, (w == 32) ? "R7 32-bit check" : "R6 16-bit check", p, m);
  endtask

  task automatic decode_bit(input logic b);
    if (b) begin
      ones++;
      if (ones >= 7) begin
        if (synced) aborts++;
        synced = 0;
      end else if (synced && nb < 2048) begin
        rxb[nb] = 1'b1; nb++;
      end
    end else begin
      if (ones == 6) begin
        flags++;
        if (synced) begin
          nb = (nb >= 7) ? nb - 7 : 0;
          if (nb > 0) close_frame();
        end
        synced = 1; nb = 0;
      end else if (ones == 5) begin
        // inserted zero dropped
      end else if (synced && nb < 2048) begin
        rxb[nb] = 1'b0; nb++;
      end
      ones = 0;
    end
  endtask

  always @(negedge clk) if (ben_q) decode_bit(tx_bit);

  task automatic push_octet(input logic [7:0] d, input logic last, input bit first);
    in_data = d; in_last = last; in_valid = 1'b1;
    forever begin
      @(negedge clk); #1;
      if (in_ready) break;
    end
    chk(bit_en == 1'b1, "R9 ready without enable", bit_en, 1);
    if (!first) chk(ben_total - last_take >= 8, "R9 octet spacing", ben_total - last_take, 8);
    last_take = ben_total;
    @(posedge clk); #1;
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  function automatic logic [7:0] pat_byte(input int pat, input int i, input int seed);
    case (pat)
      0: return 8'hFF;
      1: return 8'(i*37 + seed);
      2: return 8'h7E;
      default: return 8'(seed*11) ^ 8'(i*8'h5B) ^ 8'hA1;
    endcase
  endfunction

  task automatic expect_frame(input int len, input logic wide);
    exp_start[exp_n] = exp_ptr; exp_len[exp_n] = len; exp_wide[exp_n] = wide;
    exp_n++;
  endtask

  task automatic send_frame(input int len, input logic wide, input int pat, input int seed);
    logic [7:0] d;
    fcs32_sel = wide;
    expect_frame(len, wide);
    for (int i = 0; i < len; i++) begin
      d = pat_byte(pat, i, seed);
      exp_byte[exp_ptr] = d; exp_ptr++;
      push_octet(d, i == len - 1, i == 0);
      if (i == 0) fcs32_sel = ~wide;   // R8: late change must be ignored
    end
  endtask

  task automatic wait_rx();
    while (rx_n < exp_n) @(posedge clk);
    repeat (40 * div) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    chk(tx_bit == 1'b1, "R11 reset line value", tx_bit, 1);
    chk(in_ready == 1'b0, "R9 reset ready", in_ready, 0);
    @(negedge clk); rst_n = 1'b1;

    // idle line: R2, R5
    repeat (100) @(posedge clk);
    #1;
    chk(flags >= 10, "R2 R5 idle flags", flags, 10);
    chk(rx_n == 0, "R2 no frame while idle", rx_n, 0);

    // sweep: enable rate, check width, length, pattern (R1 R3 R4 R6 R7 R8)
    for (int dv = 1; dv <= 3; dv += 2) begin
      div = dv;
      for (int w = 0; w < 2; w++)
        for (int len = 1; len <= 6; len++)
          for (int pat = 0; pat < 4; pat++)
            send_frame(len, w[0], pat, len + 7*pat + 3*dv);
      wait_rx();
    end

    // underrun splits the frame: R10
    div = 1;
    fcs32_sel = 1'b0;
    expect_frame(2, 1'b0);
    exp_byte[exp_ptr] = 8'hA5; exp_byte[exp_ptr+1] = 8'h3C; exp_ptr += 2;
    push_octet(8'hA5, 1'b0, 1);
    push_octet(8'h3C, 1'b0, 0);
    repeat (200) @(posedge clk);
    fcs32_sel = 1'b1;
    expect_frame(1, 1'b1);
    exp_byte[exp_ptr] = 8'hC3; exp_ptr++;
    push_octet(8'hC3, 1'b1, 1);
    wait_rx();
    chk(rx_n == exp_n, "R10 frames after underrun", rx_n, exp_n);

    chk(aborts == 0, "R4 no seven-ones run inside a frame", aborts, 0);
    chk(rx_n == exp_n, "R1 frame count", rx_n, exp_n);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule